// File: doc/BRIEF.md
# UART FIFO DMA Request and Acknowledge Controller

This block sits between the host bus of a multi-channel UART and its per-channel FIFOs. For every channel it raises a transmit request when the transmit FIFO has room for more data, and a receive request when the receive FIFO holds data to collect. Each request stays up until the FIFO condition that justified it goes away, or until the DMA engine ends the transfer with a terminal-count pulse. Software controls each request with its own enable bit. In the channel's enhanced mode register these are bit 2 for transmit and bit 3 for receive. The bits reach this block as separate inputs.

An acknowledge cycle starts when the address-enable input is high and a channel's acknowledge input is low. The block then takes the host bus away from normal register decoding. While the cycle lasts, each host write strobe becomes a push into that channel's transmit FIFO, and each host read strobe becomes a pop from its receive FIFO. The address and the chip select play no part. If several acknowledge inputs are low together, only the lowest-numbered channel is served.

A separate active-low select input returns a ready-status word without any address decode. The lower half of the word holds the inverted transmit-ready flags. The upper half holds the receive-ready flags as they arrive.

Top module: `dma_handshake_ctrl`

## Requirements
- R1: A channel's acknowledge cycle is active in a cycle where `addr_en` is high and that channel's `ack_n` bit is low. If several channels qualify, only the lowest-numbered one is active. The push and pop strobes go only to the active channel and are combinational.
- R2: During an active cycle, `host_wr` produces `tx_push` and `host_rd` produces `rx_pop` for the active channel only. With no active cycle, all push and pop strobes stay low.
- R3: `reg_cs` follows the inverse of `cs_n` when no acknowledge cycle is active, and is forced low during one, whatever `cs_n` is.
- R4: A transmit request (`tx_drq`) rises at the clock edge where its enable is high, the transmit level is at or below the trigger, and either the level was above the trigger or the enable was low at the previous edge. It is visible one cycle after the inputs are applied.
- R5: A transmit request falls at the first edge where the transmit level is above its trigger. It does not re-arm until the level drops back to or below the trigger.
- R6: A receive request (`rx_drq`) rises at the edge where its enable is high, the receive level is at or above the trigger, and either that condition or the enable was false at the previous edge. It falls at the edge where the receive level is zero, and an empty FIFO takes priority over setting.
- R7: A rising edge of `term_cnt` clears both requests of the channel active at that edge and leaves the other channels unchanged. Holding `term_cnt` high does not clear again.
- R8: When a request's enable input is low at an edge, that request is low after the edge.
- R9: `stat_oe` equals the inverse of `stat_sel_n`. While it is high, bit i of `stat_byte` is the inverse of `tx_ready_n[i]` and bit NCH+i is `rx_ready_n[i]`. Otherwise `stat_byte` is zero.
- R10: Synchronous active-high `rst` leaves every request low at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_n | input | NCH | Per-channel DMA acknowledge, active low |
| addr_en | input | 1 | Address enable marking a DMA bus cycle |
| term_cnt | input | 1 | Terminal count, rising edge ends transfer |
| cs_n | input | 1 | Host chip select, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| tx_dma_en | input | NCH | Transmit request enable per channel |
| rx_dma_en | input | NCH | Receive request enable per channel |
| tx_level | input | NCH*LW | Transmit FIFO fill levels, packed |
| tx_trig | input | NCH*LW | Transmit trigger levels, packed |
| rx_level | input | NCH*LW | Receive FIFO fill levels, packed |
| rx_trig | input | NCH*LW | Receive trigger levels, packed |
| tx_ready_n | input | NCH | Transmit-ready flags, active low |
| rx_ready_n | input | NCH | Receive-ready flags, active low |
| stat_sel_n | input | 1 | Status word select, active low |
| tx_drq | output | NCH | Transmit DMA request per channel |
| rx_drq | output | NCH | Receive DMA request per channel |
| tx_push | output | NCH | Transmit FIFO write strobe per channel |
| rx_pop | output | NCH | Receive FIFO read strobe per channel |
| reg_cs | output | 1 | Gated chip select for normal register decode |
| stat_oe | output | 1 | Status word drive enable |
| stat_byte | output | 2*NCH | Ready-status word |

## Verification
The hardest case is a terminal-count rising edge that lands on exactly the clock edge where one channel holds the acknowledge, while another channel's acknowledge is also low and both have requests pending. Only the granted channel may lose its requests. A directed sequence builds this up. It first arms several channels by lowering their levels below trigger. It then drops two acknowledge inputs at once, pulses the terminal count and holds it high. After that, random traffic drawn from small level and trigger ranges makes threshold crossings, TC edges and overlapping acknowledges common. The behavioural model is compared on every clock.

// File: rtl/dmah_pkg.sv
package dmah_pkg;
    localparam int DEF_NCH = 4;
    localparam int LVL_W   = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t level;
        lvl_t trig;
    } fifo_view_t;

    typedef enum logic [0:0] {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    function automatic logic tx_room(fifo_view_t v);
        return v.level <= v.trig;
    endfunction

    function automatic logic rx_ready(fifo_view_t v);
        return v.level >= v.trig;
    endfunction
endpackage

// File: rtl/dmah_arbiter.sv
module dmah_arbiter #(
    parameter int NCH = dmah_pkg::DEF_NCH
) (
    input  logic [NCH-1:0] ack_n,
    input  logic           addr_en,
    output logic [NCH-1:0] grant,
    output logic           any_active
);
    logic [NCH-1:0] want;
    logic           found;

    assign want = ~ack_n & {NCH{addr_en}};

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (want[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any_active = found;
endmodule

// File: rtl/dmah_req_chan.sv
module dmah_req_chan
    import dmah_pkg::*;
#(
    parameter dir_e DIR = DIR_TX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tc_hit,
    input  fifo_view_t view,
    output logic       drq
);
    logic arm_cond, arm_cond_q, en_q, drop;

    generate
        if (DIR == DIR_TX) begin : g_tx
            assign arm_cond = tx_room(view);
            assign drop     = ~arm_cond;
        end else begin : g_rx
            assign arm_cond = rx_ready(view);
            assign drop     = (view.level == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            drq        <= 1'b0;
            arm_cond_q <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            arm_cond_q <= arm_cond;
            en_q       <= en;
            if (!en || tc_hit || drop)
                drq <= 1'b0;
            else if (arm_cond && (!arm_cond_q || !en_q))
                drq <= 1'b1;
        end
    end
endmodule

// File: rtl/dmah_status.sv
module dmah_status #(
    parameter int NCH = dmah_pkg::DEF_NCH,
    localparam int SW = 2 * NCH
) (
    input  logic [NCH-1:0] tx_ready_n,
    input  logic [NCH-1:0] rx_ready_n,
    input  logic           stat_sel_n,
    output logic           stat_oe,
    output logic [SW-1:0]  stat_byte
);
    assign stat_oe   = ~stat_sel_n;
    assign stat_byte = stat_oe ? {rx_ready_n, ~tx_ready_n} : '0;
endmodule

// File: rtl/dma_handshake_ctrl.sv
module dma_handshake_ctrl
    import dmah_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    localparam int LW = LVL_W,
    localparam int VW = NCH * LW,
    localparam int SW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ack_n,
    input  logic           addr_en,
    input  logic           term_cnt,
    input  logic           cs_n,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [NCH-1:0] tx_dma_en,
    input  logic [NCH-1:0] rx_dma_en,
    input  logic [VW-1:0]  tx_level,
    input  logic [VW-1:0]  tx_trig,
    input  logic [VW-1:0]  rx_level,
    input  logic [VW-1:0]  rx_trig,
    input  logic [NCH-1:0] tx_ready_n,
    input  logic [NCH-1:0] rx_ready_n,
    input  logic           stat_sel_n,
    output logic [NCH-1:0] tx_drq,
    output logic [NCH-1:0] rx_drq,
    output logic [NCH-1:0] tx_push,
    output logic [NCH-1:0] rx_pop,
    output logic           reg_cs,
    output logic           stat_oe,
    output logic [SW-1:0]  stat_byte
);
    logic [NCH-1:0] grant;
    logic           any_active;
    logic           tc_q, tc_rise;

    dmah_arbiter #(.NCH(NCH)) u_arb (
        .ack_n      (ack_n),
        .addr_en    (addr_en),
        .grant      (grant),
        .any_active (any_active)
    );

    always_ff @(posedge clk) begin
        if (rst) tc_q <= 1'b0;
        else     tc_q <= term_cnt;
    end
    assign tc_rise = term_cnt & ~tc_q;

    assign tx_push = grant & {NCH{host_wr}};
    assign rx_pop  = grant & {NCH{host_rd}};
    assign reg_cs  = ~cs_n & ~any_active;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fifo_view_t tv, rv;
        assign tv = {tx_level[i*LW +: LW], tx_trig[i*LW +: LW]};
        assign rv = {rx_level[i*LW +: LW], rx_trig[i*LW +: LW]};

        dmah_req_chan #(.DIR(DIR_TX)) u_tx (
            .clk    (clk),
            .rst    (rst),
            .en     (tx_dma_en[i]),
            .tc_hit (tc_rise & grant[i]),
            .view   (tv),
            .drq    (tx_drq[i])
        );

        dmah_req_chan #(.DIR(DIR_RX)) u_rx (
            .clk    (clk),
            .rst    (rst),
            .en     (rx_dma_en[i]),
            .tc_hit (tc_rise & grant[i]),
            .view   (rv),
            .drq    (rx_drq[i])
        );
    end

    dmah_status #(.NCH(NCH)) u_stat (
        .tx_ready_n (tx_ready_n),
        .rx_ready_n (rx_ready_n),
        .stat_sel_n (stat_sel_n),
        .stat_oe    (stat_oe),
        .stat_byte  (stat_byte)
    );
endmodule

// File: rtl/dma_handshake_chk.sv
module dma_handshake_chk #(
    parameter int NCH = 4,
    parameter int LW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] ack_n,
    input logic           addr_en,
    input logic           term_cnt,
    input logic           cs_n,
    input logic [NCH-1:0] tx_dma_en,
    input logic [NCH-1:0] rx_dma_en,
    input logic [NCH*LW-1:0] tx_level,
    input logic [NCH*LW-1:0] tx_trig,
    input logic [NCH*LW-1:0] rx_level,
    input logic [NCH-1:0] tx_drq,
    input logic [NCH-1:0] rx_drq,
    input logic [NCH-1:0] tx_push,
    input logic [NCH-1:0] rx_pop,
    input logic           reg_cs
);
    // R1: at most one channel receives strobes
    assert_push_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_push) && $onehot0(rx_pop));

    // R2: no strobes outside an acknowledge cycle
    assert_no_strobe_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!addr_en || (&ack_n)) |-> (tx_push == '0 && rx_pop == '0));

    // R3: chip select ignored during an acknowledge cycle
    assert_cs_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (addr_en && !(&ack_n) && !cs_n) |-> !reg_cs);

    // R10: reset leaves requests low
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (tx_drq == '0 && rx_drq == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5: transmit request drops when level exceeds trigger
        assert_tx_drop_above_R5: assert property (@(posedge clk) disable iff (rst)
            (tx_level[i*LW +: LW] > tx_trig[i*LW +: LW]) |=> !tx_drq[i]);

        // R6: receive request drops on empty FIFO
        assert_rx_drop_empty_R6: assert property (@(posedge clk) disable iff (rst)
            (rx_level[i*LW +: LW] == '0) |=> !rx_drq[i]);

        // R8: disabled requests fall
        assert_en_off_R8: assert property (@(posedge clk) disable iff (rst)
            (!tx_dma_en[i] || !rx_dma_en[i]) |=>
                ((!$past(tx_dma_en[i]) -> !tx_drq[i]) && (!$past(rx_dma_en[i]) -> !rx_drq[i])));
    end

    // R7: terminal count rising edge on channel 0 clears its requests
    assert_tc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (term_cnt && !$past(term_cnt) && addr_en && !ack_n[0]) |=> (!tx_drq[0] && !rx_drq[0]));
endmodule

bind dma_handshake_ctrl dma_handshake_chk #(.NCH(NCH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_n     (ack_n),
    .addr_en   (addr_en),
    .term_cnt  (term_cnt),
    .cs_n      (cs_n),
    .tx_dma_en (tx_dma_en),
    .rx_dma_en (rx_dma_en),
    .tx_level  (tx_level),
    .tx_trig   (tx_trig),
    .rx_level  (rx_level),
    .tx_drq    (tx_drq),
    .rx_drq    (rx_drq),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop),
    .reg_cs    (reg_cs)
);

// File: tb/dma_handshake_ctrl_bench.sv
module dma_handshake_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int LW    = 8;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] ack_n;
    logic addr_en, term_cnt, cs_n, host_wr, host_rd, stat_sel_n;
    logic [NCH-1:0] tx_dma_en, rx_dma_en, tx_ready_n, rx_ready_n;
    logic [NCH*LW-1:0] tx_level, tx_trig, rx_level, rx_trig;
    logic [NCH-1:0] tx_drq, rx_drq, tx_push, rx_pop;
    logic reg_cs, stat_oe;
    logic [2*NCH-1:0] stat_byte;

    always #(CLK_P/2) clk = ~clk;

    dma_handshake_ctrl u_dma_handshake_ctrl (
        .clk(clk), .rst(rst), .ack_n(ack_n), .addr_en(addr_en), .term_cnt(term_cnt),
        .cs_n(cs_n), .host_wr(host_wr), .host_rd(host_rd),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_level(tx_level), .tx_trig(tx_trig), .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_ready_n(tx_ready_n), .rx_ready_n(rx_ready_n), .stat_sel_n(stat_sel_n),
        .tx_drq(tx_drq), .rx_drq(rx_drq), .tx_push(tx_push), .rx_pop(rx_pop),
        .reg_cs(reg_cs), .stat_oe(stat_oe), .stat_byte(stat_byte)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_tx[NCH], m_rx[NCH];
    bit m_txc_q[NCH], m_rxc_q[NCH], m_txe_q[NCH], m_rxe_q[NCH];
    bit m_tc_q;

    function automatic int lv(logic [NCH*LW-1:0] v, int i);
        return int'(v[i*LW +: LW]);
    endfunction

    function automatic int granted();
        for (int i = 0; i < NCH; i++)
            if (addr_en && !ack_n[i]) return i;
        return -1;
    endfunction

    task automatic model_edge();
        int g;
        bit tcr;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_tx[i] = 0; m_rx[i] = 0; m_txc_q[i] = 0; m_rxc_q[i] = 0;
                m_txe_q[i] = 0; m_rxe_q[i] = 0;
            end
            m_tc_q = 0;
            return;
        end
        g   = granted();
        tcr = term_cnt && !m_tc_q;
        for (int i = 0; i < NCH; i++) begin
            bit room, full, hit;
            room = lv(tx_level, i) <= lv(tx_trig, i);
            full = lv(rx_level, i) >= lv(rx_trig, i);
            hit  = tcr && (g == i);
            if (!tx_dma_en[i] || hit || !room) m_tx[i] = 0;
            else if (!m_txc_q[i] || !m_txe_q[i]) m_tx[i] = 1;
            if (!rx_dma_en[i] || hit || lv(rx_level, i) == 0) m_rx[i] = 0;
            else if (full && (!m_rxc_q[i] || !m_rxe_q[i])) m_rx[i] = 1;
            m_txc_q[i] = room; m_rxc_q[i] = full;
            m_txe_q[i] = tx_dma_en[i]; m_rxe_q[i] = rx_dma_en[i];
        end
        m_tc_q = term_cnt;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [NCH-1:0] etx, erx, epu, epo;
        logic [2*NCH-1:0] est;
        int g;
        g = granted();
        for (int i = 0; i < NCH; i++) begin
            etx[i] = m_tx[i]; erx[i] = m_rx[i];
            epu[i] = host_wr && (g == i);
            epo[i] = host_rd && (g == i);
            est[i] = stat_sel_n ? 1'b0 : !tx_ready_n[i];
            est[NCH+i] = stat_sel_n ? 1'b0 : rx_ready_n[i];
        end
        chk("R4 R5 R7 R8 R10 tx_drq", 32'(tx_drq), 32'(etx));
        chk("R6 R7 R8 R10 rx_drq", 32'(rx_drq), 32'(erx));
        chk("R1 R2 tx_push", 32'(tx_push), 32'(epu));
        chk("R1 R2 rx_pop", 32'(rx_pop), 32'(epo));
        chk("R3 reg_cs", 32'(reg_cs), 32'(!cs_n && g < 0));
        chk("R9 stat_oe", 32'(stat_oe), 32'(!stat_sel_n));
        chk("R9 stat_byte", 32'(stat_byte), 32'(est));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_lv(int i, int txl, int txt, int rxl, int rxt);
        tx_level[i*LW +: LW] = LW'(txl); tx_trig[i*LW +: LW] = LW'(txt);
        rx_level[i*LW +: LW] = LW'(rxl); rx_trig[i*LW +: LW] = LW'(rxt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; ack_n = '1; addr_en = 0; term_cnt = 0; cs_n = 1; host_wr = 0; host_rd = 0;
        stat_sel_n = 1; tx_dma_en = '0; rx_dma_en = '0; tx_ready_n = '1; rx_ready_n = '1;
        tx_level = '0; tx_trig = '0; rx_level = '0; rx_trig = '0;
        repeat (3) cyc();
        // R10 reset state with requests enabled and conditions true
        tx_dma_en = '1; rx_dma_en = '1;
        for (int i = 0; i < NCH; i++) set_lv(i, 2, 8, 9, 4);
        cyc();
        rst = 0;
        cyc();              // R4 R6: requests arm one edge later
        cyc();
        // R5: channel 0 tx level above trigger, then back down re-arms
        set_lv(0, 10, 8, 9, 4); cyc();
        set_lv(0, 5, 8, 9, 4);  cyc(); cyc();
        // R6: receive empty clears channel 1
        set_lv(1, 2, 8, 0, 4); cyc();
        set_lv(1, 2, 8, 6, 4); cyc();
        // R1 R7: two acknowledges low, TC rises and stays high
        addr_en = 1; ack_n = 4'b1001; cs_n = 0; host_wr = 1; host_rd = 1;
        term_cnt = 1; cyc(); cyc(); cyc();
        term_cnt = 0; host_wr = 0; host_rd = 0; ack_n = '1; addr_en = 0; cyc();
        // R3: chip select with acknowledge low but address enable low
        ack_n = 4'b1110; cyc();
        // R8: disable drops requests
        tx_dma_en = 4'b0101; rx_dma_en = 4'b1010; cyc(); cyc();
        // R9: status select
        stat_sel_n = 0; tx_ready_n = 4'b0110; rx_ready_n = 4'b1100; cyc();
        stat_sel_n = 1; cyc();
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            rst        = ($urandom_range(0, 199) == 0);
            ack_n      = NCH'($urandom());
            addr_en    = $urandom_range(0, 2) != 0;
            term_cnt   = $urandom_range(0, 5) == 0;
            cs_n       = $urandom_range(0, 1) != 0;
            host_wr    = $urandom_range(0, 1) != 0;
            host_rd    = $urandom_range(0, 1) != 0;
            stat_sel_n = $urandom_range(0, 1) != 0;
            tx_ready_n = NCH'($urandom());
            rx_ready_n = NCH'($urandom());
            if ($urandom_range(0, 15) == 0) begin
                tx_dma_en = NCH'($urandom()); rx_dma_en = NCH'($urandom());
            end
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(0, 2) == 0)
                    set_lv(i, $urandom_range(0, 7), $urandom_range(0, 7),
                              $urandom_range(0, 7), $urandom_range(0, 7));
            cyc();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule